// File: doc/BRIEF.md
# DMA Request Routing Crossbar

This block steers seven peripheral DMA request lines onto the request inputs of four DMA channels. Four of the lines come from timers and three from UARTs. Software programs one 32-bit register that holds a 4-bit selector for each channel. Each selector either names one requester or holds a reserved code, and a reserved code leaves that channel with no routed request. Several channels may select the same requester at the same time.

A routed request does not go straight to the channel. It is gated by that channel's external-request enable and by its idle indication. The block then emits a one-cycle start pulse. After a start, a request that stays high stays silent until it has dropped and risen again. A request that rises while the channel is busy fires as soon as the channel becomes idle, provided the enable is set.

The register sits behind a single select line with a write strobe and a combinational read. Reset is synchronous and active high, and it clears the whole register.

Top module: `dreq_xbar`

## Requirements
- R1: Reset clears the routing register: a read after reset returns 0, and no channel starts while every selector is 0.
- R2: Channel c takes its selector from register bits [4c+3:4c]. A write made with `reg_sel` and `wr_en` high is used for routing from the next rising clock edge, and not before that edge.
- R3: Bits 31:16 of `rd_data` read as zero whatever was written to them. Bits 15:0 return the last written selector fields. `rd_data` is zero while `reg_sel` is low.
- R4: Selector codes 4 to 7 (binary 0100 to 0111) route timer requests `tmr_req[0]` to `tmr_req[3]` in that order.
- R5: Selector codes 8, 9 and 10 (binary 1000, 1001, 1010) route `uart_req[0]`, `uart_req[1]` and `uart_req[2]`.
- R6: Selector codes 0 to 3 and 11 to 15 route nothing: that channel never starts, whatever the request inputs do.
- R7: Any number of channels may select the same requester, and each of them starts from it at the same time.
- R8: `ch_start[c]` is never high while `ext_en[c]` is low.
- R9: `ch_start[c]` is never high while `ch_idle[c]` is low.
- R10: A start is exactly one cycle long. A routed request that stays high does not start the channel again, even after the channel has gone busy and returned to idle. It starts the channel again only after it has been low for at least one clock edge and is then high again.
- R11: A routed request that rises while the channel is busy, or while its enable is off, starts the channel in the first cycle in which both enable and idle are high, if the request is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Selects the routing register for read or write |
| wr_en | input | 1 | Write strobe, used while reg_sel is high |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero when reg_sel is low |
| tmr_req | input | 4 | Timer DMA request lines |
| uart_req | input | 3 | UART DMA request lines |
| ext_en | input | 4 | Per-channel external request enable |
| ch_idle | input | 4 | Per-channel idle indication |
| ch_start | output | 4 | Per-channel one-cycle start pulse |

## Verification
Some properties are checked by assertions on every cycle. These are the gating of each start on enable and idle, the one-cycle width of a start, the silence of reserved codes, the presence of a live requester behind every start, and the read value after reset and after a write. Other behaviour can only be shown by the bench's scenarios. This covers the full mapping from each of the sixteen codes in each channel field to each of the seven requesters, fan-out of one requester to all channels, the one-edge delay of a selector change, and the rule against retriggering on a held request. The bench sweeps every code against every requester and every enable and idle combination.

// File: rtl/dreq_xbar_pkg.sv
package dreq_xbar_pkg;
    localparam int SEL_W          = 4;
    localparam int NUM_TMR        = 4;
    localparam int NUM_UART       = 3;
    localparam int NUM_SRC        = NUM_TMR + NUM_UART;
    localparam int SRC_IDX_W      = $clog2(NUM_SRC);
    localparam int TMR_CODE_BASE  = 4;
    localparam int UART_CODE_BASE = 8;
    localparam int REG_W          = 32;

    typedef struct packed {
        logic                 hit;
        logic [SRC_IDX_W-1:0] idx;
    } route_t;

    function automatic route_t decode_sel(input logic [SEL_W-1:0] code);
        route_t r;
        int     v;
        v     = int'(code);
        r.hit = 1'b0;
        r.idx = '0;
        if (v >= TMR_CODE_BASE && v < TMR_CODE_BASE + NUM_TMR) begin
            r.hit = 1'b1;
            r.idx = SRC_IDX_W'(v - TMR_CODE_BASE);
        end else if (v >= UART_CODE_BASE && v < UART_CODE_BASE + NUM_UART) begin
            r.hit = 1'b1;
            r.idx = SRC_IDX_W'(NUM_TMR + v - UART_CODE_BASE);
        end
        return r;
    endfunction
endpackage

// File: rtl/dreq_sel_reg.sv
module dreq_sel_reg
    import dreq_xbar_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_stb,
    input  logic [REG_W-1:0]              wr_word,
    output logic [NUM_CH-1:0][SEL_W-1:0]  sel_o,
    output logic [REG_W-1:0]              rd_word
);
    localparam int FIELD_BITS = NUM_CH * SEL_W;

    logic [FIELD_BITS-1:0] fields_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (wr_stb) begin
            fields_q <= wr_word[FIELD_BITS-1:0];
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            sel_o[c] = fields_q[c*SEL_W +: SEL_W];
        end
        rd_word = REG_W'(fields_q);
    end

    // Register contents follow reset and writes on the next edge
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> rd_word == '0);
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> rd_word[FIELD_BITS-1:0] == $past(wr_word[FIELD_BITS-1:0]));
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_word[REG_W-1:FIELD_BITS] == '0);
endmodule

// File: rtl/dreq_lane.sv
module dreq_lane
    import dreq_xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [SEL_W-1:0]   sel,
    input  logic [NUM_SRC-1:0] src_vec,
    input  logic               ext_en,
    input  logic               idle,
    output logic               start
);
    route_t rt;
    logic   routed;
    logic   armed_q;

    always_comb begin
        rt     = decode_sel(sel);
        routed = rt.hit & src_vec[rt.idx];
        start  = routed & ext_en & idle & armed_q;
    end

    // Arm flag: cleared by a start, re-armed once the routed request is low
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
        end else if (start) begin
            armed_q <= 1'b0;
        end else if (!routed) begin
            armed_q <= 1'b1;
        end
    end

    assert_reserved_silent_R6: assert property (@(posedge clk) disable iff (rst)
        !rt.hit |-> !start);
    assert_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> ext_en);
    assert_needs_idle_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> idle);
    assert_one_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
endmodule

// File: rtl/dreq_xbar.sv
module dreq_xbar
    import dreq_xbar_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_sel,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic [NUM_TMR-1:0]  tmr_req,
    input  logic [NUM_UART-1:0] uart_req,
    input  logic [NUM_CH-1:0]   ext_en,
    input  logic [NUM_CH-1:0]   ch_idle,
    output logic [NUM_CH-1:0]   ch_start
);
    logic [NUM_CH-1:0][SEL_W-1:0] sel_w;
    logic [REG_W-1:0]             rd_word;
    logic [NUM_SRC-1:0]           src_vec;

    assign src_vec = {uart_req, tmr_req};
    assign rd_data = reg_sel ? rd_word : '0;

    dreq_sel_reg #(.NUM_CH(NUM_CH)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (reg_sel & wr_en),
        .wr_word (wr_data),
        .sel_o   (sel_w),
        .rd_word (rd_word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        dreq_lane u_lane (
            .clk     (clk),
            .rst     (rst),
            .sel     (sel_w[c]),
            .src_vec (src_vec),
            .ext_en  (ext_en[c]),
            .idle    (ch_idle[c]),
            .start   (ch_start[c])
        );

        // A start always has at least one live requester behind it (R4, R5)
        assert_live_source_R4: assert property (@(posedge clk) disable iff (rst)
            ch_start[c] |-> (|src_vec));
    end

    assert_read_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> rd_data == '0);
endmodule

// File: tb/dreq_xbar_tb.sv
module dreq_xbar_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  tmr_req = '0;
    logic [2:0]  uart_req = '0;
    logic [3:0]  ext_en = '0;
    logic [3:0]  ch_idle = '0;
    logic [3:0]  ch_start;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dreq_xbar u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tmr_req(tmr_req),
        .uart_req(uart_req), .ext_en(ext_en), .ch_idle(ch_idle),
        .ch_start(ch_start)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Source index 0..3 timers, 4..6 UARTs, -1 for reserved codes
    function automatic int exp_src(input int code);
        if (code >= 4 && code <= 7) return code - 4;
        if (code >= 8 && code <= 10) return 4 + code - 8;
        return -1;
    endfunction

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        reg_sel = 1'b1; wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        reg_sel = 1'b1; #1;
        check("R1 read after reset", rd_data, 32'h0);
        reg_sel = 1'b0;
        ext_en = '1; ch_idle = '1; tmr_req = '1; uart_req = '1; #1;
        check("R1 no start with zero selectors", 32'(ch_start), 32'h0);
        @(negedge clk);
        tmr_req = '0; uart_req = '0;

        // R3: upper bits read zero, lower bits stored, zero when not selected
        write_reg(32'hFFFF_FFFF);
        reg_sel = 1'b1; #1;
        check("R3 reserved bits zero", rd_data, 32'h0000_FFFF);
        reg_sel = 1'b0; #1;
        check("R3 read gated by select", rd_data, 32'h0);
        write_reg(32'hA5A5_1234);
        reg_sel = 1'b1; #1;
        check("R3 stored fields", rd_data, 32'h0000_1234);
        reg_sel = 1'b0;

        // R1: reset clears a written value
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        reg_sel = 1'b1; #1;
        check("R1 reset clears register", rd_data, 32'h0);
        reg_sel = 1'b0;

        // R2 R4 R5 R6: every channel x every code x every requester
        for (int c = 0; c < 4; c++) begin
            for (int code = 0; code < 16; code++) begin
                for (int s = 0; s < 7; s++) begin
                    logic [6:0] onehot;
                    logic [3:0] exp;
                    write_reg(32'(code) << (4 * c));
                    onehot = 7'(1) << s;
                    tmr_req = onehot[3:0]; uart_req = onehot[6:4]; #1;
                    exp = (exp_src(code) == s) ? 4'(1) << c : 4'h0;
                    check(code >= 4 && code <= 7 ? "R4 timer routing" :
                          (code >= 8 && code <= 10 ? "R5 uart routing" : "R6 reserved code silent"),
                          32'(ch_start), 32'(exp));
                    @(negedge clk);
                    tmr_req = '0; uart_req = '0;
                end
            end
        end

        // R7: one requester fanned out to all channels
        write_reg(32'h0000_9999);
        uart_req = 3'b010; #1;
        check("R7 fan-out to all channels", 32'(ch_start), 32'hF);
        @(negedge clk); uart_req = '0;
        @(negedge clk);

        // R8 R9: every enable and idle combination
        write_reg(32'h0000_4444);
        for (int e = 0; e < 16; e++) begin
            for (int i = 0; i < 16; i++) begin
                ext_en = 4'(e); ch_idle = 4'(i); tmr_req = 4'b0001; #1;
                check("R8 R9 enable and idle gating", 32'(ch_start), 32'(e & i));
                @(negedge clk); tmr_req = '0;
                @(negedge clk);
            end
        end
        ext_en = '1; ch_idle = '1;

        // R10: single pulse, held request does not retrigger
        write_reg(32'h0000_0004);
        tmr_req = 4'b0001; #1;
        check("R10 first start", 32'(ch_start), 32'h1);
        @(negedge clk); #1;
        check("R10 held request one cycle later", 32'(ch_start), 32'h0);
        ch_idle[0] = 1'b0;
        @(negedge clk); ch_idle[0] = 1'b1; #1;
        check("R10 no retrigger after idle returns", 32'(ch_start), 32'h0);
        @(negedge clk); tmr_req = '0;
        @(negedge clk); tmr_req = 4'b0001; #1;
        check("R10 restart after reassert", 32'(ch_start), 32'h1);
        @(negedge clk); tmr_req = '0;
        @(negedge clk);

        // R11: request rising while busy starts once idle
        ch_idle[0] = 1'b0; tmr_req = 4'b0001; #1;
        check("R11 busy blocks start", 32'(ch_start), 32'h0);
        @(negedge clk); ch_idle[0] = 1'b1; #1;
        check("R11 start when idle returns", 32'(ch_start), 32'h1);
        @(negedge clk); tmr_req = '0;
        @(negedge clk);

        // R2: selector change used from the next edge only
        tmr_req = 4'b0010; #1;
        check("R2 old selector ignores timer1", 32'(ch_start), 32'h0);
        reg_sel = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0005; #1;
        check("R2 no effect before edge", 32'(ch_start), 32'h0);
        @(negedge clk);
        reg_sel = 1'b0; wr_en = 1'b0; wr_data = '0; #1;
        check("R2 new selector after edge", 32'(ch_start), 32'h1);
        @(negedge clk); tmr_req = '0;
        @(negedge clk);

        finish_run();
    end
endmodule